// File: doc/BRIEF.md
# Real-Time-Clock Watchdog Timer with Expiry Steering

This block is the watchdog of a real-time clock. Software loads an 8-bit watchdog register that sets a timeout, counted in sixteenths of a second, and chooses what happens when the timeout runs out. A free-running 16 Hz tick from the clock prescaler drives the countdown. Software shows it is alive by writing or reading the watchdog register, and either access restarts the countdown.

When the countdown runs out, a watchdog flag is raised. One of two actions then follows. In interrupt mode a one-cycle interrupt pulse goes out and the countdown reloads and keeps running. In reset mode a one-cycle reset request goes out, along with a one-cycle pulse that tells the day/century register to clear its bit 6. The watchdog register is also cleared, so the watchdog stays stopped until it is programmed again.

Top module: `rtc_watchdog`

## Requirements
- R1: The timeout, in 16 Hz ticks, is the multiplier field (bits 6:2 of the watchdog register) times 4 raised to the resolution field (bits 1:0). Expiry happens on exactly that tick after a restart. For example, 0x05 gives 4 ticks and 0x7F gives 1984 ticks.
- R2: When the register holds zero, or the multiplier field is zero, the watchdog is stopped and never expires, however many ticks arrive.
- R3: A write to the watchdog register stores the value, clears the watchdog flag and restarts the countdown from the new timeout.
- R4: A read of the watchdog register returns the stored value, clears the watchdog flag and restarts the countdown from the stored timeout.
- R5: Expiry sets the watchdog flag. The flag stays set until the next write or read of the watchdog register.
- R6: Expiry with the steering bit set (bit 7 = 1) has three effects. A one-cycle reset request is raised. A one-cycle pulse is raised to clear bit 6 of the day/century register. The watchdog register becomes zero, so no further expiry occurs.
- R7: Expiry with the steering bit clear (bit 7 = 0) raises a single one-cycle interrupt pulse and no reset request.
- R8: After an interrupt-mode expiry, the countdown reloads from the stored timeout and expires again after the same number of ticks.
- R9: If a register access and the tick that would complete the timeout fall in the same cycle, the access wins. No expiry occurs and the countdown restarts in full.
- R10: After reset, the register reads zero, the flag is clear and the interrupt, reset-request and century-clear outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_16hz | input | 1 | One-cycle pulse at 16 Hz from the prescaler |
| wd_wr_en | input | 1 | Write strobe for the watchdog register |
| wd_rd_en | input | 1 | Read strobe for the watchdog register (restarts the countdown) |
| wd_wdata | input | 8 | Write data: bit 7 steering, bits 6:2 multiplier, bits 1:0 resolution |
| wd_rdata | output | 8 | Current watchdog register value |
| wd_flag | output | 1 | Watchdog flag (bit 7 of the flags register), read-only |
| wd_irq | output | 1 | One-cycle interrupt pulse on interrupt-mode expiry |
| wd_rst_req | output | 1 | One-cycle reset request on reset-mode expiry |
| century_clr | output | 1 | One-cycle pulse that clears bit 6 of the day/century register |

## Verification
The assertions assume three things about the inputs. The tick input is a single-cycle pulse. Read and write strobes are never raised together. Any input value is valid before the first tick after reset. The stimulus follows these rules. Every tick is a one-cycle pulse with idle cycles around it. Each register access is one strobe held for one cycle. All inputs change only on the falling clock edge. The only deliberate collision is a read strobe on the same cycle as a completing tick, and that case is what R9 requires.

// File: rtl/rtc_wdt_pkg.sv
package rtc_wdt_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned MULT_W = 5;
  localparam int unsigned RES_W  = 2;
  localparam int unsigned MAX_SHIFT = 2 * ((1 << RES_W) - 1);
  localparam int unsigned CNT_W  = MULT_W + MAX_SHIFT;
  localparam int unsigned STEER_BIT = REG_W - 1;

  typedef enum logic {STEER_IRQ = 1'b0, STEER_RST = 1'b1} steer_e;

  // Timeout in ticks = multiplier * 4**resolution
  function automatic logic [CNT_W-1:0] wdt_timeout(input logic [REG_W-1:0] v);
    logic [CNT_W-1:0] mult;
    mult = CNT_W'(v[RES_W +: MULT_W]);
    return mult << {v[RES_W-1:0], 1'b0};
  endfunction

  function automatic steer_e wdt_steer(input logic [REG_W-1:0] v);
    return steer_e'(v[STEER_BIT]);
  endfunction
endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import rtc_wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             clear_req,
  output logic [REG_W-1:0] value_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)         value_o <= '0;
    else if (wr_en)     value_o <= wdata;
    else if (clear_req) value_o <= '0;
  end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
  import rtc_wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] load_val,
  input  logic             steer_rst,
  output logic             running_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  // The last tick expires the count unless an access restarts it in the same cycle
  assign expire_o  = run_q && tick && (cnt_q == CNT_W'(1)) && !restart;
  assign running_o = run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (restart) begin
      cnt_q <= load_val;
      run_q <= (load_val != '0);
    end else if (expire_o) begin
      if (steer_rst) begin
        cnt_q <= '0;
        run_q <= 1'b0;
      end else begin
        cnt_q <= load_val;
        run_q <= (load_val != '0);
      end
    end else if (run_q && tick) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/wdt_expiry_act.sv
module wdt_expiry_act (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic expire,
  input  logic steer_rst,
  output logic flag_o,
  output logic irq_o,
  output logic rst_req_o,
  output logic century_clr_o,
  output logic clear_reg_o
);
  assign clear_reg_o = expire && steer_rst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_o        <= 1'b0;
      irq_o         <= 1'b0;
      rst_req_o     <= 1'b0;
      century_clr_o <= 1'b0;
    end else begin
      if (restart)     flag_o <= 1'b0;
      else if (expire) flag_o <= 1'b1;
      irq_o         <= expire && !steer_rst;
      rst_req_o     <= expire && steer_rst;
      century_clr_o <= expire && steer_rst;
    end
  end
endmodule

// File: rtl/rtc_watchdog.sv
module rtc_watchdog
  import rtc_wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_16hz,
  input  logic             wd_wr_en,
  input  logic             wd_rd_en,
  input  logic [REG_W-1:0] wd_wdata,
  output logic [REG_W-1:0] wd_rdata,
  output logic             wd_flag,
  output logic             wd_irq,
  output logic             wd_rst_req,
  output logic             century_clr
);
  logic [REG_W-1:0] value_w;
  logic [CNT_W-1:0] timeout_w;
  logic             restart_w;
  logic             expire_w;
  logic             running_w;
  logic             clear_reg_w;
  logic             steer_rst_w;

  assign restart_w   = wd_wr_en || wd_rd_en;
  assign timeout_w   = wd_wr_en ? wdt_timeout(wd_wdata) : wdt_timeout(value_w);
  assign steer_rst_w = (wdt_steer(value_w) == STEER_RST);
  assign wd_rdata    = value_w;

  wdt_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wd_wr_en), .wdata(wd_wdata),
    .clear_req(clear_reg_w), .value_o(value_w)
  );

  wdt_countdown u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_16hz), .restart(restart_w),
    .load_val(timeout_w), .steer_rst(steer_rst_w),
    .running_o(running_w), .expire_o(expire_w)
  );

  wdt_expiry_act u_act (
    .clk(clk), .rst_n(rst_n), .restart(restart_w), .expire(expire_w),
    .steer_rst(steer_rst_w), .flag_o(wd_flag), .irq_o(wd_irq),
    .rst_req_o(wd_rst_req), .century_clr_o(century_clr),
    .clear_reg_o(clear_reg_w)
  );
endmodule

// File: rtl/rtc_watchdog_chk.sv
module rtc_watchdog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] value,
  input logic       flag,
  input logic       irq,
  input logic       rst_req,
  input logic       cclr,
  input logic       expire,
  input logic       running
);
  p_zero_stops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (value == 8'h00) |-> !expire);
  p_restart_clears_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_en) |=> !flag);
  p_expire_sets_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);
  p_rst_action_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && value[7]) |=> (rst_req && cclr && value == 8'h00 && !running));
  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  p_irq_not_rst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq && rst_req));
  p_irq_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !value[7]) |=> running);
  p_access_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_en) |-> !expire);
endmodule

bind rtc_watchdog rtc_watchdog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wd_wr_en), .rd_en(wd_rd_en),
  .value(value_w), .flag(wd_flag), .irq(wd_irq), .rst_req(wd_rst_req),
  .cclr(century_clr), .expire(expire_w), .running(running_w)
);

// File: tb/rtc_watchdog_test.sv
module rtc_watchdog_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_16hz = 1'b0;
  logic       wd_wr_en = 1'b0;
  logic       wd_rd_en = 1'b0;
  logic [7:0] wd_wdata = 8'h00;
  logic [7:0] wd_rdata;
  logic       wd_flag, wd_irq, wd_rst_req, century_clr;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_watchdog uut (
    .clk(clk), .rst_n(rst_n), .tick_16hz(tick_16hz), .wd_wr_en(wd_wr_en),
    .wd_rd_en(wd_rd_en), .wd_wdata(wd_wdata), .wd_rdata(wd_rdata),
    .wd_flag(wd_flag), .wd_irq(wd_irq), .wd_rst_req(wd_rst_req),
    .century_clr(century_clr)
  );

  function automatic int ticks_for(input logic [7:0] v);
    int m, p;
    m = int'(v[6:2]);
    p = 1;
    for (int i = 0; i < int'(v[1:0]); i++) p = p * 4;
    return m * p;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [7:0] v);
    @(negedge clk); wd_wr_en = 1'b1; wd_wdata = v;
    @(negedge clk); wd_wr_en = 1'b0;
  endtask

  task automatic read_reg();
    @(negedge clk); wd_rd_en = 1'b1;
    @(negedge clk); wd_rd_en = 1'b0;
  endtask

  // Each tick is a one-cycle pulse; returns one negedge after the sampling edge
  task automatic ticks(input int n, output int irqs, output int rsts);
    irqs = 0; rsts = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_16hz = 1'b1;
      @(negedge clk); tick_16hz = 1'b0;
      irqs += int'(wd_irq);
      rsts += int'(wd_rst_req);
    end
  endtask

  task automatic t_reset();
    chk("R10 rdata", wd_rdata, 0);
    chk("R10 flag", wd_flag, 0);
    chk("R10 irq", wd_irq, 0);
    chk("R10 rst_req", wd_rst_req, 0);
    chk("R10 century_clr", century_clr, 0);
  endtask

  task automatic t_irq_mode();
    int ir, rs, n;
    n = ticks_for(8'h05);
    chk("R1 formula 0x05", n, 4);
    write_reg(8'h05);
    chk("R3 stored", wd_rdata, 8'h05);
    ticks(n - 1, ir, rs);
    chk("R1 no early irq", ir, 0);
    chk("R1 no early flag", wd_flag, 0);
    ticks(1, ir, rs);
    chk("R7 irq on expiry", wd_irq, 1);
    chk("R5 flag set", wd_flag, 1);
    chk("R7 no rst_req", wd_rst_req, 0);
    @(negedge clk);
    chk("R7 irq one cycle", wd_irq, 0);
    ticks(n - 1, ir, rs);
    chk("R8 no early second irq", ir, 0);
    ticks(1, ir, rs);
    chk("R8 reload expires again", wd_irq, 1);
    chk("R5 flag stays", wd_flag, 1);
  endtask

  task automatic t_write_clears();
    write_reg(8'h09);
    chk("R3 flag cleared", wd_flag, 0);
    chk("R3 new value", wd_rdata, 8'h09);
  endtask

  task automatic t_read_restart();
    int ir, rs;
    write_reg(8'h0C);
    ticks(3, ir, rs);
    chk("R5 flag after 3 ticks", wd_flag, 1);
    ticks(2, ir, rs);
    read_reg();
    chk("R4 read clears flag", wd_flag, 0);
    chk("R4 read value", wd_rdata, 8'h0C);
    ticks(2, ir, rs);
    chk("R4 restarted no irq", ir, 0);
    ticks(1, ir, rs);
    chk("R4 irq after full reload", wd_irq, 1);
  endtask

  task automatic t_stopped();
    int ir, rs;
    write_reg(8'h00);
    ticks(40, ir, rs);
    chk("R2 zero no irq", ir, 0);
    chk("R2 zero no flag", wd_flag, 0);
    write_reg(8'h02);
    ticks(40, ir, rs);
    chk("R2 zero multiplier no irq", ir, 0);
    chk("R2 zero multiplier no flag", wd_flag, 0);
  endtask

  task automatic t_reset_mode();
    int ir, rs;
    write_reg(8'h84);
    ticks(1, ir, rs);
    chk("R6 rst_req", wd_rst_req, 1);
    chk("R6 century_clr", century_clr, 1);
    chk("R6 reg cleared", wd_rdata, 0);
    chk("R6 no irq", wd_irq, 0);
    chk("R5 flag set", wd_flag, 1);
    @(negedge clk);
    chk("R6 rst_req one cycle", wd_rst_req, 0);
    ticks(10, ir, rs);
    chk("R6 stays stopped", rs + ir, 0);
  endtask

  task automatic t_collision();
    int ir, rs;
    write_reg(8'h04);
    @(negedge clk); tick_16hz = 1'b1; wd_rd_en = 1'b1;
    @(negedge clk); tick_16hz = 1'b0; wd_rd_en = 1'b0;
    chk("R9 access beats tick", wd_irq, 0);
    chk("R9 flag clear", wd_flag, 0);
    ticks(1, ir, rs);
    chk("R9 expires after full restart", wd_irq, 1);
  endtask

  task automatic t_longest();
    int ir, rs, n;
    n = ticks_for(8'h7F);
    chk("R1 formula 0x7F", n, 1984);
    write_reg(8'h7F);
    ticks(n - 1, ir, rs);
    chk("R1 longest no early irq", ir, 0);
    ticks(1, ir, rs);
    chk("R1 longest expiry", wd_irq, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_irq_mode();
    t_write_clears();
    t_read_restart();
    t_stopped();
    t_reset_mode();
    t_collision();
    t_longest();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule